// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines four reset requests for a small system-on-chip into one set of reset outputs. The four requests are a raw power-on input, an open-drain debug reset pin that is both sensed and driven, a single-cycle watchdog request, and a software request. Both external inputs are synchronised and deglitched. The power-on reset is held for a fixed number of cycles after its filtered input releases. The block drives separate, registered, active-high resets for the clock system, the core logic, the switch domain and the PHYs. It also pulls the debug pin low for the whole power-on phase, so an attached debugger can see that phase.

A small register port gives software two registers. The control register holds a self-clearing software-reset trigger, a bit that makes the switch domain take part in watchdog and software resets, and the PHY reset source select. The cause register is sticky and is cleared only by write-one-to-clear, so software can read it after any restart. The boot pins are captured only while the filtered power-on input is active. Every later reset keeps the stored value.

Top module: `rst_arbiter`

## Requirements
- R1: A power-on input pulse lasting GLITCH_CYC cycles or fewer has no effect. A pulse that lasts longer raises `clk_rst` and `core_rst` GLITCH_CYC+3 clock edges after the first cycle it is sampled high.
- R2: After the filtered power-on input falls, `clk_rst` stays high for POR_EXT_CYC more cycles and then releases synchronously. Watchdog and software requests are ignored during this time.
- R3: `dbg_pin_pull` (1 = drive the pad low) is high in exactly the cycles in which `clk_rst` is high.
- R4: If the pad is held low from outside for more than GLITCH_CYC cycles, and the block is not pulling it, `core_rst` and `sw_dom_rst` assert but `clk_rst` stays low. Both release once the filtered pin releases. Shorter low pulses have no effect.
- R5: `boot_mode` takes `boot_pins` only while the filtered power-on input is active. Pin changes at any other time are ignored.
- R6: A `wdt_req` pulse outside the power-on phase raises `core_rst` two edges later, for exactly HOLD_CYC cycles.
- R7: Writing 1 to control bit 0 (address 0) starts the same HOLD_CYC-cycle core reset. Bit 0 reads 1 until the sequence ends, then clears itself.
- R8: `sw_dom_rst` joins a watchdog or software reset only when control bit 1 was set at the time of the request. Power-on and debug resets always assert it.
- R9: The cause register (address 1) has bit 0 for power-on or debug, bit 1 for watchdog and bit 2 for software. It is never cleared by a reset. Writing 1 to a bit clears it, a cause that occurs in the same cycle wins, and causes that occur together all set their bits.
- R10: Control bit 2 selects the PHY reset. With 0, `phy_rst` follows the power-on phase, timed like `clk_rst`. With 1, `phy_rst` is `sw_phy_req` OR NOT `mgmt_en`, registered once.
- R11: `reg_rdata` returns the register chosen by `reg_addr` one edge later, with unused bits zero. The power-on phase clears the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_rst | input | 1 | Raw power-on reset, active high, asynchronous |
| dbg_pin_lvl | input | 1 | Sensed level of the open-drain debug pad (0 = low) |
| dbg_pin_pull | output | 1 | 1 = drive the debug pad low |
| wdt_req | input | 1 | Single-cycle watchdog expiry request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = cause |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one edge after the address |
| boot_pins | input | BOOT_W | Boot configuration pins |
| boot_mode | output | BOOT_W | Stored boot configuration |
| mgmt_en | input | 1 | Switch management interface enabled |
| sw_phy_req | input | 1 | PHY reset request from the switch |
| core_rst | output | 1 | Core logic reset |
| clk_rst | output | 1 | Clock system reset |
| sw_dom_rst | output | 1 | Switch domain reset |
| phy_rst | output | 1 | PHY reset |

## Verification
Each external input passes through two synchroniser stages and a run-length filter that needs GLITCH_CYC+1 differing samples. The filtered power-on state therefore acts on the outputs GLITCH_CYC+3 edges after the input changes. A watchdog or software request is registered into the hold counter and then into the output, so its reset appears two edges later. Register reads and the switch PHY path each take one edge. The bench keeps its own reference model, which steps once per rising edge and carries these delays. At every falling edge it compares all outputs with the model, and directed checks at settled points confirm durations, widths and register contents.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CAUSE = 1'b1;

  localparam int CAUSE_HW  = 0;
  localparam int CAUSE_WDT = 1;
  localparam int CAUSE_SW  = 2;
  localparam int CAUSE_W   = 3;

  typedef struct packed {
    logic phy_sel;
    logic dom_join;
    logic swr;
  } ctrl_t;
endpackage

// File: rtl/rst_deglitch.sv
module rst_deglitch #(
  parameter int   GLITCH_CYC = 3,
  parameter logic INIT       = 1'b0
) (
  input  logic clk,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(GLITCH_CYC + 1) + 1;

  logic [1:0]    sync_q  = {2{INIT}};
  logic [CW-1:0] run_q   = '0;
  logic          clean_q = INIT;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[0], raw};
    if (sync_q[1] != clean_q) begin
      if (run_q == CW'(GLITCH_CYC)) begin
        clean_q <= sync_q[1];
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign clean = clean_q;
endmodule

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int POR_EXT_CYC = 20,
  parameter int HOLD_CYC    = 8
) (
  input  logic clk,
  input  logic por_f,
  input  logic dbg_f,
  input  logic trig,
  input  logic join_en,
  input  logic phy_sel,
  input  logic phy_sw_src,
  output logic por_act,
  output logic hold_end,
  output logic clk_rst,
  output logic core_rst,
  output logic sw_dom_rst,
  output logic phy_rst,
  output logic dbg_pull
);
  localparam int EW = $clog2(POR_EXT_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [EW-1:0] ext_q    = EW'(POR_EXT_CYC);
  logic [HW-1:0] hold_q   = '0;
  logic          joined_q = 1'b0;
  logic          clk_q    = 1'b1;
  logic          core_q   = 1'b1;
  logic          dom_q    = 1'b1;
  logic          phy_q    = 1'b1;
  logic          pull_q   = 1'b1;
  logic          hold_run;

  assign por_act  = por_f | (ext_q != '0);
  assign hold_run = (hold_q != '0);
  assign hold_end = (hold_q == HW'(1)) & ~trig & ~por_act;

  always_ff @(posedge clk) begin
    if (por_f)             ext_q <= EW'(POR_EXT_CYC);
    else if (ext_q != '0)  ext_q <= ext_q - 1'b1;

    if (por_act) begin
      hold_q   <= '0;
      joined_q <= 1'b0;
    end else if (trig) begin
      hold_q   <= HW'(HOLD_CYC);
      joined_q <= join_en;
    end else if (hold_run) begin
      hold_q <= hold_q - 1'b1;
    end

    clk_q  <= por_act;
    pull_q <= por_act;
    core_q <= por_act | dbg_f | hold_run;
    dom_q  <= por_act | dbg_f | (joined_q & hold_run);
    phy_q  <= phy_sel ? phy_sw_src : por_act;
  end

  assign clk_rst    = clk_q;
  assign core_rst   = core_q;
  assign sw_dom_rst = dom_q;
  assign phy_rst    = phy_q;
  assign dbg_pull   = pull_q;
endmodule

// File: rtl/rst_regs.sv
module rst_regs
  import rst_pkg::*;
#(
  parameter int BOOT_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                por_f,
  input  logic                por_act,
  input  logic                dbg_f,
  input  logic                wdt_req,
  input  logic                hold_end,
  input  logic                reg_we,
  input  logic                reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [BOOT_W-1:0]   boot_pins,
  output logic                sw_go,
  output logic                join_en,
  output logic                phy_sel,
  output logic [BOOT_W-1:0]   boot_mode,
  output logic [CAUSE_W-1:0]  cause,
  output logic [DATA_W-1:0]   reg_rdata
);
  localparam int PAD_W = DATA_W - CAUSE_W;

  ctrl_t              ctrl_q  = '0;
  logic [CAUSE_W-1:0] cause_q = '0;
  logic [BOOT_W-1:0]  boot_q  = '0;
  logic [DATA_W-1:0]  rd_q    = '0;
  logic [CAUSE_W-1:0] cause_set;
  logic               wr_ctrl;
  logic               wr_cause;

  assign wr_ctrl  = reg_we & (reg_addr == ADDR_CTRL);
  assign wr_cause = reg_we & (reg_addr == ADDR_CAUSE);
  assign sw_go    = wr_ctrl & reg_wdata[0] & ~ctrl_q.swr & ~por_act;

  always_comb begin
    cause_set            = '0;
    cause_set[CAUSE_HW]  = por_f | dbg_f;
    cause_set[CAUSE_WDT] = wdt_req & ~por_act;
    cause_set[CAUSE_SW]  = sw_go;
  end

  always_ff @(posedge clk) begin
    if (por_act) begin
      ctrl_q <= '0;
    end else begin
      if (sw_go)         ctrl_q.swr <= 1'b1;
      else if (hold_end) ctrl_q.swr <= 1'b0;
      if (wr_ctrl) begin
        ctrl_q.dom_join <= reg_wdata[1];
        ctrl_q.phy_sel  <= reg_wdata[2];
      end
    end

    if (wr_cause) cause_q <= (cause_q & ~reg_wdata[CAUSE_W-1:0]) | cause_set;
    else          cause_q <= cause_q | cause_set;

    if (por_f) boot_q <= boot_pins;

    rd_q <= (reg_addr == ADDR_CAUSE) ? {{PAD_W{1'b0}}, cause_q}
                                     : {{PAD_W{1'b0}}, ctrl_q};
  end

  assign join_en   = ctrl_q.dom_join;
  assign phy_sel   = ctrl_q.phy_sel;
  assign boot_mode = boot_q;
  assign cause     = cause_q;
  assign reg_rdata = rd_q;
endmodule

// File: rtl/rst_arbiter.sv
module rst_arbiter
  import rst_pkg::*;
#(
  parameter int GLITCH_CYC  = 3,
  parameter int POR_EXT_CYC = 20,
  parameter int HOLD_CYC    = 8,
  parameter int BOOT_W      = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              pwr_on_rst,
  input  logic              dbg_pin_lvl,
  output logic              dbg_pin_pull,
  input  logic              wdt_req,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [BOOT_W-1:0] boot_pins,
  output logic [BOOT_W-1:0] boot_mode,
  input  logic              mgmt_en,
  input  logic              sw_phy_req,
  output logic              core_rst,
  output logic              clk_rst,
  output logic              sw_dom_rst,
  output logic              phy_rst
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]    raw_vec;
  logic [NSRC-1:0]    flt_vec;
  logic               por_f;
  logic               dbg_f;
  logic               por_act;
  logic               hold_end;
  logic               sw_go;
  logic               join_en;
  logic               phy_sel;
  logic [CAUSE_W-1:0] cause_q;

  // index 0: power-on input, index 1: debug pad sensed low while not self-driven
  assign raw_vec = {~dbg_pin_lvl & ~dbg_pin_pull, pwr_on_rst};

  for (genvar i = 0; i < NSRC; i++) begin : g_flt
    rst_deglitch #(
      .GLITCH_CYC(GLITCH_CYC),
      .INIT      ((i == 0) ? 1'b1 : 1'b0)
    ) u_flt (
      .clk  (clk),
      .raw  (raw_vec[i]),
      .clean(flt_vec[i])
    );
  end

  assign por_f = flt_vec[0];
  assign dbg_f = flt_vec[1];

  rst_seq #(
    .POR_EXT_CYC(POR_EXT_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .por_f     (por_f),
    .dbg_f     (dbg_f),
    .trig      (wdt_req | sw_go),
    .join_en   (join_en),
    .phy_sel   (phy_sel),
    .phy_sw_src(sw_phy_req | ~mgmt_en),
    .por_act   (por_act),
    .hold_end  (hold_end),
    .clk_rst   (clk_rst),
    .core_rst  (core_rst),
    .sw_dom_rst(sw_dom_rst),
    .phy_rst   (phy_rst),
    .dbg_pull  (dbg_pin_pull)
  );

  rst_regs #(
    .BOOT_W(BOOT_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .por_f    (por_f),
    .por_act  (por_act),
    .dbg_f    (dbg_f),
    .wdt_req  (wdt_req),
    .hold_end (hold_end),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .boot_pins(boot_pins),
    .sw_go    (sw_go),
    .join_en  (join_en),
    .phy_sel  (phy_sel),
    .boot_mode(boot_mode),
    .cause    (cause_q),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/rst_arbiter_chk.sv
module rst_arbiter_chk #(
  parameter int BOOT_W = 4
) (
  input logic              clk,
  input logic              clk_rst,
  input logic              core_rst,
  input logic              sw_dom_rst,
  input logic              dbg_pin_pull,
  input logic              wdt_req,
  input logic              reg_we,
  input logic              reg_addr,
  input logic [BOOT_W-1:0] boot_mode,
  input logic [2:0]        cause_q
);
  always @(posedge clk) begin
    assert_pull_tracks_R3: assert (dbg_pin_pull == clk_rst)
      else $error("debug pull differs from clock reset");
  end

  assert_boot_frozen_R5: assert property (@(posedge clk) disable iff (clk_rst)
    $stable(boot_mode))
    else $error("boot mode changed outside power-on");

  assert_wdt_resets_R6: assert property (@(posedge clk) disable iff (clk_rst)
    wdt_req |=> ##1 core_rst)
    else $error("watchdog request did not reset core");

  assert_dom_in_core_R8: assert property (@(posedge clk) disable iff (clk_rst)
    sw_dom_rst |-> core_rst)
    else $error("switch domain reset without core reset");

  assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (clk_rst)
    !(reg_we && reg_addr) |=> ((cause_q & $past(cause_q)) == $past(cause_q)))
    else $error("cause bit lost without clear write");
endmodule

bind rst_arbiter rst_arbiter_chk #(.BOOT_W(BOOT_W)) u_chk (
  .clk         (clk),
  .clk_rst     (clk_rst),
  .core_rst    (core_rst),
  .sw_dom_rst  (sw_dom_rst),
  .dbg_pin_pull(dbg_pin_pull),
  .wdt_req     (wdt_req),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .boot_mode   (boot_mode),
  .cause_q     (cause_q)
);

// File: tb/test_rst_arbiter.sv
`timescale 1ns/1ps
module test_rst_arbiter;
  localparam int G = 3;
  localparam int EXT = 20;
  localparam int HOLD = 8;
  localparam int BW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic pwr_on_rst = 1'b1;
  logic ext_dbg_low = 1'b0;
  logic wdt_req = 1'b0;
  logic reg_we = 1'b0;
  logic reg_addr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [BW-1:0] boot_pins = 4'hA;
  logic mgmt_en = 1'b0;
  logic sw_phy_req = 1'b0;
  logic dbg_pin_lvl, dbg_pin_pull;
  logic [DW-1:0] reg_rdata;
  logic [BW-1:0] boot_mode;
  logic core_rst, clk_rst, sw_dom_rst, phy_rst;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign dbg_pin_lvl = ~(dbg_pin_pull | ext_dbg_low);

  rst_arbiter #(.GLITCH_CYC(G), .POR_EXT_CYC(EXT), .HOLD_CYC(HOLD),
                .BOOT_W(BW), .DATA_W(DW)) i_rst_arbiter (
    .clk(clk), .pwr_on_rst(pwr_on_rst), .dbg_pin_lvl(dbg_pin_lvl),
    .dbg_pin_pull(dbg_pin_pull), .wdt_req(wdt_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .boot_pins(boot_pins), .boot_mode(boot_mode), .mgmt_en(mgmt_en),
    .sw_phy_req(sw_phy_req), .core_rst(core_rst), .clk_rst(clk_rst),
    .sw_dom_rst(sw_dom_rst), .phy_rst(phy_rst));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit pq[$] = '{1'b1, 1'b1};
  bit dq[$] = '{1'b0, 1'b0};
  bit m_pf = 1, m_df = 0;
  int prun = 0, drun = 0;
  int m_ecnt = EXT, m_hold = 0;
  bit m_joined = 0, m_swb = 0, m_join = 0, m_psel = 0;
  bit [2:0] m_stat = 0;
  bit [BW-1:0] m_boot = 0;
  bit m_clk = 1, m_pull = 1, m_core = 1, m_swd = 1, m_phy = 1;
  bit [DW-1:0] m_rd = 0;

  always @(posedge clk) begin
    bit pa, go, trig, d, raw_d;
    bit [2:0] set;
    int p_hold;
    bit p_join;
    pa = m_pf || (m_ecnt != 0);
    go = reg_we && !reg_addr && reg_wdata[0] && !m_swb && !pa;
    trig = wdt_req || go;
    p_hold = m_hold;
    p_join = m_join;
    raw_d = ext_dbg_low && !m_pull;
    m_rd = reg_addr ? {5'b0, m_stat} : {5'b0, m_psel, m_join, m_swb};
    set = {go, wdt_req && !pa, m_pf || m_df};
    if (reg_we && reg_addr) m_stat = (m_stat & ~reg_wdata[2:0]) | set;
    else m_stat = m_stat | set;
    if (m_pf) m_boot = boot_pins;
    m_clk = pa;
    m_pull = pa;
    m_core = pa || m_df || (p_hold != 0);
    m_swd = pa || m_df || (m_joined && p_hold != 0);
    m_phy = m_psel ? (sw_phy_req || !mgmt_en) : pa;
    if (pa) begin
      m_swb = 0; m_join = 0; m_psel = 0;
    end else begin
      if (go) m_swb = 1;
      else if (m_swb && p_hold == 1 && !trig) m_swb = 0;
      if (reg_we && !reg_addr) begin m_join = reg_wdata[1]; m_psel = reg_wdata[2]; end
    end
    if (pa) begin m_hold = 0; m_joined = 0; end
    else if (trig) begin m_hold = HOLD; m_joined = p_join; end
    else if (m_hold != 0) m_hold--;
    if (m_pf) m_ecnt = EXT; else if (m_ecnt != 0) m_ecnt--;
    d = pq.pop_front(); pq.push_back(pwr_on_rst);
    if (d != m_pf) begin prun++; if (prun == G + 1) begin m_pf = d; prun = 0; end end
    else prun = 0;
    d = dq.pop_front(); dq.push_back(raw_d);
    if (d != m_df) begin drun++; if (drun == G + 1) begin m_df = d; drun = 0; end end
    else drun = 0;
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R2 clk_rst vs model", 32'(clk_rst), 32'(m_clk));
      check("R3 dbg_pin_pull vs model", 32'(dbg_pin_pull), 32'(m_pull));
      check("R6 core_rst vs model", 32'(core_rst), 32'(m_core));
      check("R8 sw_dom_rst vs model", 32'(sw_dom_rst), 32'(m_swd));
      check("R10 phy_rst vs model", 32'(phy_rst), 32'(m_phy));
      check("R5 boot_mode vs model", 32'(boot_mode), 32'(m_boot));
      check("R11 reg_rdata vs model", 32'(reg_rdata), 32'(m_rd));
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] v);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    step(1);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] v);
    reg_addr = a;
    step(1);
    v = reg_rdata;
  endtask

  task automatic count_high(input int n, output int c_core, output int c_dom, output int c_clk);
    c_core = 0; c_dom = 0; c_clk = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      c_core += int'(core_rst); c_dom += int'(sw_dom_rst); c_clk += int'(clk_rst);
    end
  endtask

  initial begin
    logic [DW-1:0] v;
    int a, b, c;
    step(2);
    check("R1 reset state clk_rst", 32'(clk_rst), 1);
    check("R1 reset state core_rst", 32'(core_rst), 1);
    step(8);
    pwr_on_rst = 1'b0;
    step(40);
    check("R2 clk_rst released", 32'(clk_rst), 0);
    check("R2 core_rst released", 32'(core_rst), 0);
    check("R5 boot captured", 32'(boot_mode), 32'hA);
    boot_pins = 4'h5;
    step(5);
    check("R5 pins ignored outside power-on", 32'(boot_mode), 32'hA);

    // R1 short power-on glitch
    pwr_on_rst = 1'b1; step(G); pwr_on_rst = 1'b0;
    count_high(15, a, b, c);
    check("R1 glitch ignored", 32'(c), 0);

    // R4 debug pin glitch, then long hold
    ext_dbg_low = 1'b1; step(G); ext_dbg_low = 1'b0;
    count_high(12, a, b, c);
    check("R4 debug glitch ignored", 32'(a), 0);
    ext_dbg_low = 1'b1; step(10);
    check("R4 core held by debug pin", 32'(core_rst), 1);
    check("R4 switch held by debug pin", 32'(sw_dom_rst), 1);
    check("R4 clock system untouched", 32'(clk_rst), 0);
    ext_dbg_low = 1'b0; step(12);
    check("R4 debug release", 32'(core_rst), 0);

    rd(1'b1, v);
    check("R9 cause shows power-on/debug", 32'(v), 1);
    wr(1'b1, 8'h01); step(1);
    rd(1'b1, v);
    check("R9 write-one clears", 32'(v), 0);

    // R6 watchdog without switch join
    wdt_req = 1'b1; step(1); wdt_req = 1'b0;
    count_high(20, a, b, c);
    check("R6 watchdog hold length", 32'(a), HOLD);
    check("R8 switch stays out without join", 32'(b), 0);
    rd(1'b1, v);
    check("R9 watchdog cause", 32'(v), 2);

    // R7 software reset with join
    wr(1'b0, 8'h03);
    rd(1'b0, v);
    check("R7 software bit reads set", 32'(v), 3);
    step(20);
    rd(1'b0, v);
    check("R7 software bit self-clears", 32'(v), 2);
    rd(1'b1, v);
    check("R9 causes accumulate", 32'(v), 6);

    wr(1'b0, 8'h00);
    wr(1'b0, 8'h02);
    wdt_req = 1'b1; step(1); wdt_req = 1'b0;
    count_high(20, a, b, c);
    check("R8 switch joins watchdog", 32'(b), HOLD);

    // R9 simultaneous causes
    wr(1'b1, 8'h07); step(1);
    wdt_req = 1'b1; wr(1'b0, 8'h03); wdt_req = 1'b0;
    step(20);
    rd(1'b1, v);
    check("R9 simultaneous causes", 32'(v), 6);

    // R10 PHY source select
    wr(1'b0, 8'h06);
    mgmt_en = 1'b0; step(3);
    check("R10 phy held while management off", 32'(phy_rst), 1);
    mgmt_en = 1'b1; step(3);
    check("R10 phy released", 32'(phy_rst), 0);
    sw_phy_req = 1'b1; step(3);
    check("R10 switch phy request", 32'(phy_rst), 1);
    sw_phy_req = 1'b0;

    // second power-on
    boot_pins = 4'h5;
    pwr_on_rst = 1'b1; step(10); pwr_on_rst = 1'b0;
    step(45);
    check("R5 boot resampled at power-on", 32'(boot_mode), 32'h5);
    rd(1'b1, v);
    check("R9 cause survives power-on", 32'(v), 7);
    rd(1'b0, v);
    check("R11 control cleared by power-on", 32'(v), 0);
    check("R10 phy follows power-on when deselected", 32'(phy_rst), 0);

    step(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule